// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on the write clock with an active-low write strobe. A consumer pops them on the read clock with an active-low read strobe. Pointers cross between the domains as Gray code through multi-flop synchronizers. Each status flag is computed and registered in the domain that owns it: availability and almost-empty on the read clock, fullness, half-full and almost-full on the write clock.

The timing mode is captured from `mode_sel` while master reset is held, and the later level of that pin has no effect. In standard mode the consumer must strobe every word out, including the first one after empty. The read-side flag is an active-low empty indication and the write-side flag is an active-low full indication. Both pass through two register stages. In fall-through mode the oldest word is moved into an output register with no strobe. That register acts as one extra storage slot. The read-side flag becomes an active-low output-valid indication and the write-side flag an active-low input-ready indication. Because of the extra slot, every level threshold sits one word higher in fall-through mode. The empty offset and the full offset are parameters.

Top module: `dmfifo`

## Requirements
- R1: The mode is captured while `mrst_n` is low: `mode_sel`=0 selects standard mode and `mode_sel`=1 selects fall-through mode. Changing `mode_sel` after reset has no effect.
- R2: In standard mode, `dout` changes only on a read clock edge where `rd_en_n`=0 and the FIFO holds data, and it then shows the oldest word. A read strobe while empty leaves `dout` unchanged, and a write alone never changes `dout`.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` after the third read clock rising edge that follows the write edge, with `rd_en_n` held high. Later words stay behind it until a read strobe.
- R4: `rd_flag` is 1 when data is stored in standard mode. It becomes 1 on the second read clock edge after the synchronized write pointer shows data. In fall-through mode `rd_flag` is 0 exactly while `dout` holds a valid unread word.
- R5: `almost_empty_n` is 1 when the stored count is at least E+1 in standard mode, or at least E+2 in fall-through mode, where E = EMPTY_OFS. The count in fall-through mode includes the output register. It is 0 otherwise.
- R6: `half_full_n` is 0 when the count is at least D/2+1 in standard mode, or at least D/2+2 in fall-through mode, where D is the depth 2**AW.
- R7: `almost_full_n` is 0 when the count is at least D−M in standard mode, or at least D+1−M in fall-through mode, where M = FULL_OFS.
- R8: The write side is full at D words in standard mode and at D+1 words in fall-through mode. When full, `wr_flag` is 0 in standard mode and 1 in fall-through mode, and a write strobe is dropped. The first read releases the full state.
- R9: While `mrst_n` is low, both pointers clear. `rd_flag` shows empty (0 in standard mode, 1 in fall-through mode). `wr_flag` shows not-full (1 in standard mode, 0 in fall-through mode). `almost_empty_n`=0, `half_full_n`=1, `almost_full_n`=1 and `dout`=0.
- R10: Words leave in the order they were written, with no loss or duplication, in both modes.
- R11: Each cross-domain pointer changes by at most one bit per clock of its own domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asserted asynchronously |
| mode_sel | input | 1 | Mode select, captured during reset (1 = fall-through) |
| wr_en_n | input | 1 | Write strobe, active low |
| din | input | DW | Write data |
| rd_en_n | input | 1 | Read strobe, active low |
| dout | output | DW | Read data register |
| rd_flag | output | 1 | Empty flag (standard) or output-valid flag (fall-through), active low |
| wr_flag | output | 1 | Full flag (standard) or input-ready flag (fall-through), active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| half_full_n | output | 1 | Half-full flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The bench walks the count up from empty to full and back down in both modes, checking every flag at every count. A threshold placed one word off, or a fall-through mode that does not shift its thresholds, fails at exactly one count. It samples the three-edge fall-through arrival and the two-stage empty flag on exact edges. An extra output stage, or a missing one, shows up there as a one-cycle shift. It also writes into a full FIFO and reads from an empty one. A design that stores the dropped word returns an extra value on the final read. A design that pops when empty corrupts `dout` or the order.

// File: rtl/dmfifo_pkg.sv
`timescale 1ns/1ps
package dmfifo_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } fifo_mode_e;

   // Gray to binary for up to 32 bits; callers zero-extend and truncate.
   function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/dmfifo_sync.sv
`timescale 1ns/1ps
module dmfifo_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/dmfifo_ram.sv
`timescale 1ns/1ps
module dmfifo_ram #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dmfifo_wctl.sv
`timescale 1ns/1ps
module dmfifo_wctl
   import dmfifo_pkg::*;
#(
   parameter int AW       = 4,
   parameter int FULL_OFS = 2
) (
   input  logic          wclk,
   input  logic          mrst_n,
   input  logic          mode_sel,
   input  logic          wr_en_n,
   input  logic [AW:0]   rgray_s,
   output logic [AW-1:0] waddr,
   output logic          we,
   output logic [AW:0]   wgray,
   output logic          fwft,
   output logic          wr_flag,
   output logic          half_full_n,
   output logic          almost_full_n
);
   localparam int          DEPTH    = 1 << AW;
   localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);
   localparam logic [AW:0] CNT_HALF = (AW+1)'(DEPTH/2 + 1);
   localparam logic [AW:0] CNT_AF   = (AW+1)'(DEPTH - FULL_OFS);

   fifo_mode_e  mode_q;
   logic [AW:0] wbin, wbin_nxt, rbin_s, wcnt, wcnt_nxt;
   logic        push, full1, full2;

   // Mode captured only while reset is held.
   always_ff @(posedge wclk) begin
      if (!mrst_n) mode_q <= fifo_mode_e'(mode_sel);
   end
   assign fwft = (mode_q == MODE_FWFT);

   // Write-side count covers the memory only; in fall-through mode the
   // output register adds the extra slot on the read side.
   always_comb begin
      rbin_s   = (AW+1)'(gray_to_bin(32'(rgray_s)));
      wcnt     = wbin - rbin_s;
      push     = !wr_en_n && (wcnt != CNT_FULL);
      wbin_nxt = wbin + {{AW{1'b0}}, push};
      wcnt_nxt = wbin_nxt - rbin_s;
   end

   always_ff @(posedge wclk or negedge mrst_n) begin
      if (!mrst_n) begin
         wbin          <= '0;
         wgray         <= '0;
         full1         <= 1'b0;
         full2         <= 1'b0;
         half_full_n   <= 1'b1;
         almost_full_n <= 1'b1;
      end else begin
         wbin          <= wbin_nxt;
         wgray         <= wbin_nxt ^ (wbin_nxt >> 1);
         full1         <= (wcnt_nxt == CNT_FULL);
         full2         <= full1;
         half_full_n   <= !(wcnt_nxt >= CNT_HALF);
         almost_full_n <= !(wcnt_nxt >= CNT_AF);
      end
   end

   assign waddr   = wbin[AW-1:0];
   assign we      = push;
   assign wr_flag = fwft ? full1 : ~full2;
endmodule

// File: rtl/dmfifo_rctl.sv
`timescale 1ns/1ps
module dmfifo_rctl
   import dmfifo_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 4,
   parameter int EMPTY_OFS = 2
) (
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          mode_sel,
   input  logic          rd_en_n,
   input  logic [AW:0]   wgray_s,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          fwft,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          almost_empty_n
);
   localparam logic [AW:0] AE_STD  = (AW+1)'(EMPTY_OFS + 1);
   localparam logic [AW:0] AE_FWFT = (AW+1)'(EMPTY_OFS + 2);

   fifo_mode_e  mode_q;
   logic [AW:0] rbin, rbin_nxt, wbin_s, mcnt, mcnt_nxt, total_nxt;
   logic        has, pop, consume, ov, ov_nxt, avail1, avail2, ae_hit;

   always_ff @(posedge rclk) begin
      if (!mrst_n) mode_q <= fifo_mode_e'(mode_sel);
   end
   assign fwft = (mode_q == MODE_FWFT);

   always_comb begin
      wbin_s  = (AW+1)'(gray_to_bin(32'(wgray_s)));
      mcnt    = wbin_s - rbin;
      has     = (mcnt != '0);
      consume = fwft && ov && !rd_en_n;
      if (fwft) begin
         pop    = has && (!ov || consume);
         ov_nxt = pop || (ov && !consume);
      end else begin
         pop    = !rd_en_n && has;
         ov_nxt = 1'b0;
      end
      rbin_nxt  = rbin + {{AW{1'b0}}, pop};
      mcnt_nxt  = wbin_s - rbin_nxt;
      total_nxt = mcnt_nxt + {{AW{1'b0}}, ov_nxt};
      ae_hit    = fwft ? (total_nxt >= AE_FWFT) : (total_nxt >= AE_STD);
   end

   always_ff @(posedge rclk or negedge mrst_n) begin
      if (!mrst_n) begin
         rbin           <= '0;
         rgray          <= '0;
         ov             <= 1'b0;
         dout           <= '0;
         avail1         <= 1'b0;
         avail2         <= 1'b0;
         almost_empty_n <= 1'b0;
      end else begin
         rbin           <= rbin_nxt;
         rgray          <= rbin_nxt ^ (rbin_nxt >> 1);
         ov             <= ov_nxt;
         avail1         <= (total_nxt != '0);
         avail2         <= avail1;
         almost_empty_n <= ae_hit;
         if (pop) dout  <= rdata;
      end
   end

   assign raddr   = rbin[AW-1:0];
   assign rd_flag = fwft ? ~ov : avail2;
endmodule

// File: rtl/dmfifo.sv
`timescale 1ns/1ps
module dmfifo #(
   parameter int DW          = 8,
   parameter int AW          = 4,
   parameter int EMPTY_OFS   = 2,
   parameter int FULL_OFS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          mrst_n,
   input  logic          mode_sel,
   input  logic          wr_en_n,
   input  logic [DW-1:0] din,
   input  logic          rd_en_n,
   output logic [DW-1:0] dout,
   output logic          rd_flag,
   output logic          wr_flag,
   output logic          almost_empty_n,
   output logic          half_full_n,
   output logic          almost_full_n
);
   localparam int DEPTH = 1 << AW;

   if (AW < 2 || AW > 16) begin : g_bad_aw
      $error("dmfifo: AW must lie in 2..16");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dmfifo: DW must be at least 1");
   end
   if (EMPTY_OFS < 0 || EMPTY_OFS > DEPTH/2 - 2) begin : g_bad_eofs
      $error("dmfifo: EMPTY_OFS out of range");
   end
   if (FULL_OFS < 1 || FULL_OFS > DEPTH/2 - 2) begin : g_bad_fofs
      $error("dmfifo: FULL_OFS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dmfifo: SYNC_STAGES must be at least 2");
   end

   logic [AW-1:0] waddr, raddr;
   logic          we, fwft_w, fwft_r;
   logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
   logic [DW-1:0] rdata;

   dmfifo_ram #(.DW(DW), .AW(AW)) u_ram (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
      .raddr(raddr), .rdata(rdata)
   );

   dmfifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(mrst_n), .d(wgray), .q(wgray_s)
   );

   dmfifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(mrst_n), .d(rgray), .q(rgray_s)
   );

   dmfifo_wctl #(.AW(AW), .FULL_OFS(FULL_OFS)) u_wctl (
      .wclk(wclk), .mrst_n(mrst_n), .mode_sel(mode_sel), .wr_en_n(wr_en_n),
      .rgray_s(rgray_s), .waddr(waddr), .we(we), .wgray(wgray), .fwft(fwft_w),
      .wr_flag(wr_flag), .half_full_n(half_full_n), .almost_full_n(almost_full_n)
   );

   dmfifo_rctl #(.DW(DW), .AW(AW), .EMPTY_OFS(EMPTY_OFS)) u_rctl (
      .rclk(rclk), .mrst_n(mrst_n), .mode_sel(mode_sel), .rd_en_n(rd_en_n),
      .wgray_s(wgray_s), .rdata(rdata), .raddr(raddr), .rgray(rgray),
      .fwft(fwft_r), .dout(dout), .rd_flag(rd_flag),
      .almost_empty_n(almost_empty_n)
   );
endmodule

// File: rtl/dmfifo_chk.sv
`timescale 1ns/1ps
module dmfifo_chk #(
   parameter int DW = 8,
   parameter int AW = 4
) (
   input logic          wclk,
   input logic          rclk,
   input logic          mrst_n,
   input logic          rd_en_n,
   input logic [DW-1:0] dout,
   input logic          rd_flag,
   input logic          wr_flag,
   input logic          half_full_n,
   input logic          almost_full_n,
   input logic [AW:0]   wgray,
   input logic [AW:0]   rgray,
   input logic          fwft_w,
   input logic          fwft_r
);
   AST_WPTR_GRAY_STEP: assert property (@(posedge wclk) disable iff (!mrst_n)
      $countones(wgray ^ $past(wgray)) <= 1); // R11

   AST_RPTR_GRAY_STEP: assert property (@(posedge rclk) disable iff (!mrst_n)
      $countones(rgray ^ $past(rgray)) <= 1); // R11

   AST_MODE_HELD: assert property (@(posedge rclk) disable iff (!mrst_n)
      $stable(fwft_r)); // R1

   AST_STD_DOUT_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n)
      (!fwft_r && rd_en_n) |=> $stable(dout)); // R2

   AST_FWFT_WORD_HOLD: assert property (@(posedge rclk) disable iff (!mrst_n)
      (fwft_r && !rd_flag && rd_en_n) |=> (!rd_flag && $stable(dout))); // R3

   AST_AF_IMPLIES_HF: assert property (@(posedge wclk) disable iff (!mrst_n)
      !almost_full_n |-> !half_full_n); // R7

   AST_FULL_IMPLIES_AF: assert property (@(posedge wclk) disable iff (!mrst_n)
      (fwft_w && wr_flag) |-> !almost_full_n); // R8
endmodule

bind dmfifo dmfifo_chk #(.DW(DW), .AW(AW)) u_chk (
   .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .rd_en_n(rd_en_n),
   .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag),
   .half_full_n(half_full_n), .almost_full_n(almost_full_n),
   .wgray(wgray), .rgray(rgray), .fwft_w(fwft_w), .fwft_r(fwft_r)
);

// File: tb/dmfifo_tb.sv
`timescale 1ns/1ps
module dmfifo_tb;
   localparam int DW = 8;
   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int EO = 2;
   localparam int MO = 2;

   logic          clk = 1'b0;
   logic          mrst_n = 1'b0;
   logic          mode_sel = 1'b0;
   logic          wr_en_n = 1'b1;
   logic          rd_en_n = 1'b1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          rd_flag, wr_flag, ae_n, hf_n, af_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dmfifo #(.DW(DW), .AW(AW), .EMPTY_OFS(EO), .FULL_OFS(MO)) u_dut (
      .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .mode_sel(mode_sel),
      .wr_en_n(wr_en_n), .din(din), .rd_en_n(rd_en_n), .dout(dout),
      .rd_flag(rd_flag), .wr_flag(wr_flag), .almost_empty_n(ae_n),
      .half_full_n(hf_n), .almost_full_n(af_n)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input bit m);
      @(negedge clk);
      mrst_n = 1'b0; mode_sel = m; wr_en_n = 1'b1; rd_en_n = 1'b1;
      tick(6);
      mrst_n = 1'b1; mode_sel = ~m;   // later level must not matter (R1)
      tick(4);
   endtask

   task automatic push(input logic [DW-1:0] d);
      @(negedge clk); wr_en_n = 1'b0; din = d;
      @(negedge clk); wr_en_n = 1'b1;
   endtask

   task automatic pulse_read;
      @(negedge clk); rd_en_n = 1'b0;
      @(negedge clk); rd_en_n = 1'b1;
   endtask

   // Expected flags for a stored count c in the given mode.
   task automatic chk_levels(input bit m, input int c, input string ctx);
      int sh;
      sh = m ? 1 : 0;
      chk("R5", {ctx, " almost_empty_n"}, int'(ae_n), int'(c >= EO + 1 + sh));
      chk("R6", {ctx, " half_full_n"},    int'(hf_n), int'(!(c >= D/2 + 1 + sh)));
      chk("R7", {ctx, " almost_full_n"},  int'(af_n), int'(!(c >= D - MO + sh)));
      if (m) chk("R8", {ctx, " input-ready"}, int'(wr_flag), int'(c >= D + 1));
      else   chk("R8", {ctx, " full"},        int'(wr_flag), int'(!(c >= D)));
   endtask

   task automatic t_reset(input bit m);
      do_reset(m);
      chk("R9", "rd_flag after reset", int'(rd_flag), m ? 1 : 0);
      chk("R9", "wr_flag after reset", int'(wr_flag), m ? 0 : 1);
      chk("R9", "almost_empty_n after reset", int'(ae_n), 0);
      chk("R9", "half_full_n after reset", int'(hf_n), 1);
      chk("R9", "almost_full_n after reset", int'(af_n), 1);
      chk("R9", "dout after reset", int'(dout), 0);
   endtask

   task automatic t_std_basic;
      do_reset(1'b0);
      pulse_read; tick(8);
      chk("R2", "read while empty dout", int'(dout), 0);
      chk("R2", "read while empty flag", int'(rd_flag), 0);
      push(8'hA5);
      tick(3);
      chk("R4", "empty flag before second stage", int'(rd_flag), 0);
      tick(1);
      chk("R4", "empty flag after second stage", int'(rd_flag), 1);
      tick(8);
      chk("R2", "no fall-through in standard mode", int'(dout), 0);
      chk("R1", "mode held standard after pin change", int'(rd_flag), 1);
      pulse_read;
      chk("R2", "requested read data", int'(dout), 'hA5);
      tick(8);
      chk("R4", "empty after last read", int'(rd_flag), 0);
      pulse_read; tick(4);
      chk("R2", "read on empty keeps dout", int'(dout), 'hA5);
   endtask

   task automatic t_fwft_basic;
      do_reset(1'b1);
      push(8'h3C);
      tick(2);
      chk("R3", "not valid after two read edges", int'(rd_flag), 1);
      tick(1);
      chk("R3", "valid after third read edge", int'(rd_flag), 0);
      chk("R3", "fall-through data", int'(dout), 'h3C);
      push(8'h5A); tick(8);
      chk("R3", "second word waits for strobe", int'(dout), 'h3C);
      pulse_read;
      chk("R3", "second word after strobe", int'(dout), 'h5A);
      chk("R4", "output still valid", int'(rd_flag), 0);
      pulse_read; tick(8);
      chk("R4", "output not valid when drained", int'(rd_flag), 1);
   endtask

   task automatic t_std_fill;
      do_reset(1'b0);
      for (int k = 1; k <= D; k++) begin
         push(DW'(8'h40 + k)); tick(8);
         chk_levels(1'b0, k, "std fill");
      end
      push(8'hEE); tick(8);
      chk("R8", "write into full dropped, still full", int'(wr_flag), 0);
      for (int k = 1; k <= D; k++) begin
         pulse_read;
         chk("R10", "std order", int'(dout), 'h40 + k);
         tick(8);
         chk_levels(1'b0, D - k, "std drain");
         chk("R4", "std empty flag", int'(rd_flag), int'(D - k != 0));
      end
      pulse_read; tick(4);
      chk("R8", "dropped word never stored (std)", int'(dout), 'h40 + D);
   endtask

   task automatic t_fwft_fill;
      do_reset(1'b1);
      for (int k = 1; k <= D + 1; k++) begin
         push(DW'(8'h80 + k)); tick(8);
         chk_levels(1'b1, k, "fwft fill");
      end
      push(8'hEE); tick(8);
      chk("R8", "write into full dropped, not ready", int'(wr_flag), 1);
      for (int k = 1; k <= D + 1; k++) begin
         chk("R10", "fwft order", int'(dout), 'h80 + k);
         pulse_read; tick(8);
         chk_levels(1'b1, D + 1 - k, "fwft drain");
         chk("R4", "fwft valid flag", int'(rd_flag), int'(D + 1 - k == 0));
      end
      pulse_read; tick(8);
      chk("R8", "dropped word never stored (fwft)", int'(rd_flag), 1);
   endtask

   initial begin
      t_reset(1'b0);
      t_reset(1'b1);
      t_std_basic;
      t_fwft_basic;
      t_std_fill;
      t_fwft_fill;
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule